// File: doc/BRIEF.md
# Two-Wire Bus Slave Controller With Status Codes

This block is the slave side of a two-wire serial bus (I2C-style). It watches the clock and data lines through synchronizers and detects START and STOP conditions. It collects address bytes and responds to its own 7-bit address. It can also respond to the all-zero general call address when that is enabled. Once addressed, it either receives data bytes from the master or sends bytes that software has loaded. Both bus lines are open-drain: the block only ever pulls a line low or releases it.

Software runs every transfer through a status code and an event flag. At the end of each byte, and on a STOP or repeated START while the slave is addressed, the block does three things. It latches a status code, raises the flag, and holds the clock line low from its next low phase. It keeps the clock low until software writes the clear bit. An acknowledge-enable bit decides whether received bytes are acknowledged and whether the address is recognised at all. Clearing it in the middle of a transfer ends that transfer cleanly:
- A receiver refuses the next byte.
- A transmitter sends one last byte and then lets go of the data line.

Top module: `tws_slave`

## Requirements
- R1: After reset the flag is low, the status reads 0xF8, and neither bus line is pulled low.
- R2: Address bytes are sampled MSB first on SCL rising edges. The seven address bits are followed by a direction bit, where 0 means write. An address equal to the value in bits 7:1 of a write to select 0 is acknowledged by pulling SDA low during the ninth clock, provided acknowledge-enable (bit 0 of a write to select 1) is set and the direction is write. After that ninth clock the flag rises with status 0x60.
- R3: The same address with direction 1 (read) gives status 0xA8. After the flag is cleared, the byte written to select 2 is driven MSB first, and SDA changes only while SCL is low.
- R4: While the flag is set, SCL is held low from its next low phase. It is released only after a write to select 1 with bit 7 set clears the flag. While the flag is clear, the status reads 0xF8.
- R5: A received data byte is readable on rxByte. If acknowledge-enable is set, the byte is acknowledged and the status is 0x80. If it is clear, SDA stays released on the ninth clock, the status is 0x88, and the slave stops being addressed.
- R6: In transmit, the status after each byte is set as follows. A master ACK with acknowledge-enable set gives 0xB8. A master NACK gives 0xC0. A master ACK with acknowledge-enable clear gives 0xC8. After 0xC0 or 0xC8 the slave leaves SDA released, so the master reads 0xFF and no flag rises.
- R7: With acknowledge-enable clear, the own address is neither acknowledged nor flagged. Setting the bit again restores address recognition.
- R8: The general call address 0x00 is acknowledged only when bit 0 of the select-0 write is set. It then gives the same status codes as the own address.
- R9: A foreign address is not acknowledged and raises no flag.
- R10: A STOP or repeated START while addressed raises the flag with status 0xA0. A STOP while not addressed raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| sclDriveLow | output | 1 | Pull the bus clock line low (stretch) |
| sdaDriveLow | output | 1 | Pull the bus data line low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 address, 1 control, 2 transmit data |
| wrData | input | DATA_W | Register write data |
| intFlag | output | 1 | Event flag awaiting software |
| statusCode | output | 8 | Status of the last event, 0xF8 when no flag |
| rxByte | output | DATA_W | Last received data byte |

## Verification
The assertions rely on the following bus behaviour from the master:
- It changes SDA only while SCL is low, except for START and STOP conditions.
- It never issues those conditions while the slave pulls SDA low.
- It keeps each SCL phase many system clocks long.

The bench master meets these conditions:
- It uses twenty-cycle half periods.
- It sets data a quarter period after each falling edge.
- It waits for the SCL line to read high before counting its high phase, which honours stretching.
- Before a STOP that ends a read in which it acknowledged the final byte, it has software load 0xFF, so the slave never holds SDA low when the STOP arrives.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sclLevel;
    logic sdaLevel;
  } busEvT;

  typedef struct packed {
    logic sampleBit;
    logic latchRx;
    logic loadTx;
    logic shiftTx;
  } dpStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX
  } slvStateT;

  localparam logic [7:0] STAT_NONE    = 8'hF8;
  localparam logic [7:0] STAT_ADDR_W  = 8'h60;
  localparam logic [7:0] STAT_RX_ACK  = 8'h80;
  localparam logic [7:0] STAT_RX_NACK = 8'h88;
  localparam logic [7:0] STAT_STOP    = 8'hA0;
  localparam logic [7:0] STAT_ADDR_R  = 8'hA8;
  localparam logic [7:0] STAT_TX_ACK  = 8'hB8;
  localparam logic [7:0] STAT_TX_NACK = 8'hC0;
  localparam logic [7:0] STAT_TX_LAST = 8'hC8;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

endpackage

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobeT          strobe,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txWrData,
  output busEvT             busEv,
  output logic [DATA_W-1:0] rxShift,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit
);

  logic [1:0] lineIn;
  logic [1:0] lineNow;
  logic [1:0] linePrev;

  assign lineIn = {sdaIn, sclIn};

  // one synchronizer chain plus history flop per bus line (0 = clock, 1 = data)
  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [SYNC_STAGES-1:0] stages;
    logic                   prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stages <= '1;
        prev   <= 1'b1;
      end else begin
        stages <= {stages[SYNC_STAGES-2:0], lineIn[g]};
        prev   <= stages[SYNC_STAGES-1];
      end
    end
    assign lineNow[g]  = stages[SYNC_STAGES-1];
    assign linePrev[g] = prev;
  end

  always_comb begin
    busEv.sclLevel  = lineNow[0];
    busEv.sdaLevel  = lineNow[1];
    busEv.sclRise   = lineNow[0] & ~linePrev[0];
    busEv.sclFall   = ~lineNow[0] & linePrev[0];
    busEv.startSeen = lineNow[0] & linePrev[0] & linePrev[1] & ~lineNow[1];
    busEv.stopSeen  = lineNow[0] & linePrev[0] & ~linePrev[1] & lineNow[1];
  end

  logic [DATA_W-1:0] txData;
  logic [DATA_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxByte  <= '0;
      txData  <= '1;
      txShift <= '1;
    end else begin
      if (strobe.sampleBit) rxShift <= {rxShift[DATA_W-2:0], lineNow[1]};
      if (strobe.latchRx)   rxByte  <= rxShift;
      if (txWr)             txData  <= txWrData;
      if (strobe.loadTx)       txShift <= txData;
      else if (strobe.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  assign txBit = txShift[DATA_W-1];

endmodule

// File: rtl/tws_control.sv
module tws_control
  import tws_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvT             busEv,
  input  logic [DATA_W-1:0] rxShift,
  input  logic              txBit,
  input  logic              addrWr,
  input  logic              ctrlWr,
  input  logic [DATA_W-1:0] wrData,
  output dpStrobeT          strobe,
  output logic              intFlag,
  output logic [7:0]        statusCode,
  output logic              sclDriveLow,
  output logic              sdaDriveLow
);

  localparam int ADDR_W   = DATA_W - 1;
  localparam int CNT_W    = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] END_SLOT = CNT_W'(DATA_W + 1);

  slvStateT          state;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] ownAddr;
  logic              gcEn, ackEn, flag, holdScl;
  logic [7:0]        code;
  logic              ackOut, txDrive, readReq, rxAckd, mAckd;

  logic clearReq, addrHit, inByte;
  assign clearReq = ctrlWr & wrData[DATA_W-1];
  assign addrHit  = ackEn & ((rxShift[DATA_W-1:1] == ownAddr) |
                             (gcEn & (rxShift[DATA_W-1:1] == '0)));
  assign inByte   = bitCnt < ACK_SLOT;

  always_comb begin
    strobe.sampleBit = busEv.sclRise & inByte & ((state == ST_ADDR) | (state == ST_RX));
    strobe.latchRx   = busEv.sclFall & (state == ST_RX) & (bitCnt == ACK_SLOT);
    strobe.shiftTx   = busEv.sclFall & (state == ST_TX) & (bitCnt != '0) & inByte;
    strobe.loadTx    = clearReq & flag & (state == ST_TX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ownAddr <= '0;
      gcEn    <= 1'b0;
      ackEn   <= 1'b0;
      flag    <= 1'b0;
      holdScl <= 1'b0;
      code    <= STAT_NONE;
      ackOut  <= 1'b0;
      txDrive <= 1'b0;
      readReq <= 1'b0;
      rxAckd  <= 1'b0;
      mAckd   <= 1'b0;
    end else begin
      if (addrWr) begin
        ownAddr <= wrData[DATA_W-1:1];
        gcEn    <= wrData[0];
      end
      if (ctrlWr)        ackEn   <= wrData[0];
      if (clearReq)      flag    <= 1'b0;
      if (strobe.loadTx) txDrive <= 1'b1;
      holdScl <= flag & (holdScl | ~busEv.sclLevel);

      if (busEv.startSeen || busEv.stopSeen) begin
        if (state == ST_RX || state == ST_TX) begin
          flag <= 1'b1;
          code <= STAT_STOP;
        end
        state   <= busEv.startSeen ? ST_ADDR : ST_IDLE;
        bitCnt  <= '0;
        ackOut  <= 1'b0;
        txDrive <= 1'b0;
      end else if (busEv.sclRise && state != ST_IDLE) begin
        bitCnt <= bitCnt + 1'b1;
        if (state == ST_TX && bitCnt == ACK_SLOT) mAckd <= ~busEv.sdaLevel;
      end else if (busEv.sclFall && state != ST_IDLE) begin
        if (bitCnt == ACK_SLOT) begin
          case (state)
            ST_ADDR: begin
              if (addrHit) begin
                ackOut  <= 1'b1;
                readReq <= rxShift[0];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_RX: begin
              ackOut <= ackEn;
              rxAckd <= ackEn;
            end
            ST_TX:   txDrive <= 1'b0;
            default: ;
          endcase
        end else if (bitCnt == END_SLOT) begin
          bitCnt <= '0;
          ackOut <= 1'b0;
          flag   <= 1'b1;
          case (state)
            ST_ADDR: begin
              code  <= readReq ? STAT_ADDR_R : STAT_ADDR_W;
              state <= readReq ? ST_TX : ST_RX;
            end
            ST_RX: begin
              code <= rxAckd ? STAT_RX_ACK : STAT_RX_NACK;
              if (!rxAckd) state <= ST_IDLE;
            end
            ST_TX: begin
              if (!mAckd) begin
                code  <= STAT_TX_NACK;
                state <= ST_IDLE;
              end else if (!ackEn) begin
                code  <= STAT_TX_LAST;
                state <= ST_IDLE;
              end else begin
                code <= STAT_TX_ACK;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign intFlag     = flag;
  assign statusCode  = flag ? code : STAT_NONE;
  assign sclDriveLow = holdScl;
  assign sdaDriveLow = ackOut | (txDrive & ~txBit);

  // data line only moves while the clock line is low
  assert_sda_low_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !busEv.sclLevel);

  assert_write_addr_rx_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flag) && code == STAT_ADDR_W) |-> state == ST_RX);

  assert_release_after_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |=> !sclDriveLow);

  assert_nack_unaddressed_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flag) && code == STAT_RX_NACK) |-> state == ST_IDLE);

  assert_detached_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !txDrive);

  assert_ack_when_addressed_R9: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> state != ST_IDLE);

endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              intFlag,
  output logic [7:0]        statusCode,
  output logic [DATA_W-1:0] rxByte
);

  busEvT             busEv;
  dpStrobeT          strobe;
  logic [DATA_W-1:0] rxShift;
  logic              txBit;
  logic              addrWr, ctrlWr, dataWr;

  assign addrWr = wrEn & (wrSel == SEL_ADDR);
  assign ctrlWr = wrEn & (wrSel == SEL_CTRL);
  assign dataWr = wrEn & (wrSel == SEL_DATA);

  tws_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strobe   (strobe),
    .txWr     (dataWr),
    .txWrData (wrData),
    .busEv    (busEv),
    .rxShift  (rxShift),
    .rxByte   (rxByte),
    .txBit    (txBit)
  );

  tws_control #(.DATA_W(DATA_W)) uControl (
    .clk         (clk),
    .rstN        (rstN),
    .busEv       (busEv),
    .rxShift     (rxShift),
    .txBit       (txBit),
    .addrWr      (addrWr),
    .ctrlWr      (ctrlWr),
    .wrData      (wrData),
    .strobe      (strobe),
    .intFlag     (intFlag),
    .statusCode  (statusCode),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow)
  );

endmodule

// File: tb/sim_tws_slave.sv
`timescale 1ns/1ps
module sim_tws_slave;

  localparam int HALF  = 20;
  localparam int QTR   = 10;
  localparam int LIMIT = 190000;
  localparam logic [6:0] OWN = 7'h2A;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       sclDriveLow, sdaDriveLow, intFlag;
  logic [7:0] statusCode, rxByte;
  logic       sclLine, sdaLine;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign sclLine = mScl & ~sclDriveLow;
  assign sdaLine = mSda & ~sdaDriveLow;

  tws_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .intFlag(intFlag), .statusCode(statusCode), .rxByte(rxByte)
  );

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc >= LIMIT && !finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, LIMIT);
      finishRun();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRxCode(input logic ae);
    return ae ? 8'h80 : 8'h88;
  endfunction

  function automatic logic [7:0] expTxCode(input logic mack, input logic ae);
    if (!mack) return 8'hC0;
    if (!ae)   return 8'hC8;
    return 8'hB8;
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    while (!sclLine) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    waitN(2);
  endtask

  task automatic busStart();
    mSda = 1'b1; mScl = 1'b1;
    waitSclHigh(); waitN(HALF);
    mSda = 1'b0; waitN(HALF);
    mScl = 1'b0; waitN(HALF);
  endtask

  task automatic busRestart();
    mSda = 1'b1; waitN(QTR);
    mScl = 1'b1; waitSclHigh(); waitN(HALF);
    mSda = 1'b0; waitN(HALF);
    mScl = 1'b0; waitN(HALF);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitN(QTR);
    mScl = 1'b1; waitSclHigh(); waitN(HALF);
    mSda = 1'b1; waitN(HALF);
  endtask

  task automatic writeBit(input logic b);
    mSda = b; waitN(QTR);
    mScl = 1'b1; waitSclHigh(); waitN(HALF);
    mScl = 1'b0; waitN(QTR);
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; waitN(QTR);
    mScl = 1'b1; waitSclHigh(); waitN(QTR);
    b = sdaLine; waitN(QTR);
    mScl = 1'b0; waitN(QTR);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(s);
    ack = ~s;
    waitN(4);
  endtask

  task automatic recvByte(output logic [7:0] d, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      readBit(s);
      d[i] = s;
    end
    writeBit(~mack);
    waitN(4);
  endtask

  task automatic expectFlag(input string req, input logic [7:0] code);
    chk({req, " flag"}, intFlag, 1'b1);
    chk({req, " status"}, statusCode, code);
    chk({req, " scl held"}, sclDriveLow, 1'b1);
  endtask

  task automatic expectNoFlag(input string req);
    waitN(6);
    chk({req, " no flag"}, intFlag, 1'b0);
    chk({req, " idle status"}, statusCode, 8'hF8);
  endtask

  task automatic stopAddressed(input string req);
    busStop(); waitN(4);
    chk({req, " stop flag"}, intFlag, 1'b1);
    chk({req, " stop status"}, statusCode, 8'hA0);
    regWrite(2'd1, 8'h81);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int unsigned seedVal;
    seedVal = $urandom(32'd4711);

    waitN(5);
    chk("R1 flag", intFlag, 1'b0);
    chk("R1 status", statusCode, 8'hF8);
    chk("R1 scl", sclDriveLow, 1'b0);
    chk("R1 sda", sdaDriveLow, 1'b0);
    rstN = 1'b1;
    waitN(5);

    regWrite(2'd0, {OWN, 1'b0});
    regWrite(2'd1, 8'h01);

    // directed write transfer with a NACK on the second byte
    busStart();
    sendByte({OWN, 1'b0}, ack);
    chk("R2 address ack", ack, 1'b1);
    expectFlag("R2", 8'h60);
    waitN(60);
    chk("R4 still stretching", sclLine, 1'b0);
    regWrite(2'd1, 8'h81);
    chk("R4 released", sclDriveLow, 1'b0);
    chk("R4 idle status", statusCode, 8'hF8);
    sendByte(8'h5C, ack);
    chk("R5 ack", ack, 1'b1);
    expectFlag("R5", 8'h80);
    chk("R5 byte", rxByte, 8'h5C);
    regWrite(2'd1, 8'h80);
    sendByte(8'hA3, ack);
    chk("R5 nack", ack, 1'b0);
    expectFlag("R5 nack", 8'h88);
    chk("R5 byte nack", rxByte, 8'hA3);
    regWrite(2'd1, 8'h80);
    sendByte(8'h11, ack);
    chk("R5 unaddressed ack", ack, 1'b0);
    expectNoFlag("R5 unaddressed");
    busStop();
    expectNoFlag("R10 stop unaddressed");

    // acknowledge-enable gating of the address
    busStart();
    sendByte({OWN, 1'b0}, ack);
    chk("R7 ignored ack", ack, 1'b0);
    expectNoFlag("R7 ignored");
    busStop();
    regWrite(2'd1, 8'h01);
    busStart();
    sendByte({OWN, 1'b0}, ack);
    chk("R7 resumed ack", ack, 1'b1);
    expectFlag("R7 resumed", 8'h60);
    regWrite(2'd1, 8'h81);
    stopAddressed("R10");

    // directed read: ACK, then last byte, then detached
    busStart();
    sendByte({OWN, 1'b1}, ack);
    chk("R3 address ack", ack, 1'b1);
    expectFlag("R3", 8'hA8);
    regWrite(2'd2, 8'hC6);
    regWrite(2'd1, 8'h81);
    recvByte(b, 1'b1);
    chk("R3 data", b, 8'hC6);
    expectFlag("R6 ack", 8'hB8);
    regWrite(2'd2, 8'h3B);
    regWrite(2'd1, 8'h80);
    recvByte(b, 1'b1);
    chk("R3 last data", b, 8'h3B);
    expectFlag("R6 last", 8'hC8);
    regWrite(2'd1, 8'h80);
    recvByte(b, 1'b0);
    chk("R6 detached ones", b, 8'hFF);
    expectNoFlag("R6 detached");
    busStop();
    expectNoFlag("R6 stop after detach");

    regWrite(2'd1, 8'h01);
    busStart();
    sendByte({OWN, 1'b1}, ack);
    expectFlag("R3 second", 8'hA8);
    regWrite(2'd2, 8'h91);
    regWrite(2'd1, 8'h81);
    recvByte(b, 1'b0);
    chk("R3 data 91", b, 8'h91);
    expectFlag("R6 nack", 8'hC0);
    regWrite(2'd1, 8'h81);
    busStop();
    expectNoFlag("R6 stop after nack");

    // foreign address
    busStart();
    sendByte({7'h15, 1'b0}, ack);
    chk("R9 foreign ack", ack, 1'b0);
    expectNoFlag("R9 foreign");
    busStop();

    // general call
    busStart();
    sendByte(8'h00, ack);
    chk("R8 gc disabled ack", ack, 1'b0);
    expectNoFlag("R8 gc disabled");
    busStop();
    regWrite(2'd0, {OWN, 1'b1});
    busStart();
    sendByte(8'h00, ack);
    chk("R8 gc ack", ack, 1'b1);
    expectFlag("R8 gc", 8'h60);
    regWrite(2'd1, 8'h81);
    sendByte(8'h77, ack);
    expectFlag("R8 gc data", 8'h80);
    chk("R8 gc byte", rxByte, 8'h77);
    regWrite(2'd1, 8'h81);
    busRestart();
    waitN(4);
    expectFlag("R10 restart", 8'hA0);
    regWrite(2'd1, 8'h81);
    sendByte({OWN, 1'b1}, ack);
    chk("R10 readdress ack", ack, 1'b1);
    expectFlag("R10 readdress", 8'hA8);
    regWrite(2'd2, 8'h5A);
    regWrite(2'd1, 8'h81);
    recvByte(b, 1'b0);
    chk("R3 data 5A", b, 8'h5A);
    expectFlag("R6 nack 2", 8'hC0);
    regWrite(2'd1, 8'h81);
    busStop();
    expectNoFlag("R10 stop after nack");

    // constrained random transfers
    for (int t = 0; t < 14; t++) begin
      int kind;
      int n;
      bit addressed;
      kind = int'($urandom % 5);
      n = 1 + int'($urandom % 3);
      addressed = 1;
      regWrite(2'd1, 8'h81);
      if (kind == 0) begin
        logic [6:0] fa;
        fa = 7'($urandom);
        if (fa == OWN || fa == 7'h00) fa = 7'h33;
        busStart();
        sendByte({fa, 1'($urandom)}, ack);
        chk("R9 random foreign ack", ack, 1'b0);
        expectNoFlag("R9 random foreign");
        busStop();
      end else if (kind < 3) begin
        busStart();
        sendByte({OWN, 1'b0}, ack);
        chk("R2 random ack", ack, 1'b1);
        expectFlag("R2 random", 8'h60);
        for (int i = 0; i < n; i++) begin
          logic [7:0] d;
          logic ae;
          d = 8'($urandom);
          ae = 1'($urandom);
          regWrite(2'd1, {1'b1, 6'd0, ae});
          sendByte(d, ack);
          chk("R5 random ack", ack, ae);
          expectFlag("R5 random", expRxCode(ae));
          chk("R5 random byte", rxByte, d);
          if (!ae) begin
            addressed = 0;
            break;
          end
        end
        regWrite(2'd1, 8'h81);
        if (addressed) stopAddressed("R10 random");
        else begin
          busStop();
          expectNoFlag("R10 random unaddressed");
        end
      end else begin
        busStart();
        sendByte({OWN, 1'b1}, ack);
        chk("R3 random ack", ack, 1'b1);
        expectFlag("R3 random", 8'hA8);
        for (int i = 0; i < n; i++) begin
          logic [7:0] d;
          logic [7:0] c;
          logic ae;
          logic mack;
          d = 8'($urandom);
          ae = 1'($urandom);
          mack = 1'($urandom);
          regWrite(2'd2, d);
          regWrite(2'd1, {1'b1, 6'd0, ae});
          recvByte(b, mack);
          chk("R3 random data", b, d);
          c = expTxCode(mack, ae);
          expectFlag("R6 random", c);
          if (c != 8'hB8) begin
            addressed = 0;
            break;
          end
        end
        if (addressed) begin
          regWrite(2'd2, 8'hFF);
          regWrite(2'd1, 8'h81);
          stopAddressed("R10 random read");
        end else begin
          regWrite(2'd1, 8'h81);
          busStop();
          expectNoFlag("R6 random detached");
        end
      end
    end

    waitN(20);
    finishRun();
  end

endmodule